// File: doc/BRIEF.md
# Four-Word Serial Telemetry Transmitter

This block streams a burst of four 32-bit samples out of the chip on one data line, with a gated bit clock beside it so that an external capture device can pick up each bit. A burst is started by a one-cycle strobe that marks the start of the frame settle state. On that edge all four input words are copied into an internal shift buffer. Producers may then change their outputs at once without harming the burst.

Every word goes out as one flag slot, always driven high, and then its 32 data bits. The least significant bit goes first, so the sign bit is always the last bit of a word. Word 0 is sent first and word 3 last. The 132 bit slots are followed by 8 quiet cycles, so a burst always takes 140 fast-clock cycles. This fixed length lets the system prove that the stream is finished before the next compute pass starts. The data line changes only on rising edges of the fast clock. In slot cycles the bit clock is the inverted fast clock, so data moves on the bit clock's falling edge and holds still on its rising edge.

The controller is a four-state machine. IDLE waits for the strobe. IDLE→FLAG when the strobe is sampled high, and this also loads the buffer. FLAG→DATA always. DATA→DATA while bits of the current word remain. DATA→FLAG after the 32nd bit of words 0 to 2. DATA→TAIL after the 32nd bit of word 3. TAIL→TAIL for the quiet cycles. TAIL→IDLE after the 8th quiet cycle.

Top module: `tlm_serializer`

## Requirements
- R1: While reset is held and just after it, the block is idle: busy is 0, the data line is 0 and the bit clock stays low.
- R2: A strobe sampled high on a rising edge while idle starts a burst. Busy is 1 from the next cycle, and the first slot is a flag slot.
- R3: A burst sends word 0, word 1, word 2, word 3 in that order. Each word is preceded by exactly one flag slot, and the data line is 1 in that slot.
- R4: The 32 bits of a word follow its flag slot least significant bit first, and bit 31 (sign) is the last of them.
- R5: Busy stays high for exactly 140 consecutive cycles per burst, and the first 132 of those cycles are bit slots.
- R6: In the 8 cycles after the last bit slot, the data line is 0 and the bit clock stays low while busy stays high.
- R7: In a bit slot the bit clock is low during the high phase of the fast clock and high during its low phase. Outside bit slots the bit clock is low at all times.
- R8: Changes on the word inputs after the starting edge do not alter the burst in progress.
- R9: A strobe sampled while busy is 1, including in the last busy cycle, is ignored. The burst is neither restarted nor lengthened.
- R10: If the strobe is held high continuously, a new burst starts on the first idle edge. There is exactly one idle cycle between bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| settle_sync | input | 1 | Strobe marking the start of the frame settle state |
| word_bus | input | 128 | Four words; word k is bits [32k+31:32k] |
| ser_data | output | 1 | Serial data line |
| bit_clk | output | 1 | Gated bit clock, active only in bit slots |
| busy | output | 1 | High for the 140 cycles of a burst |

## Verification
Busy and the first flag slot must appear in the cycle right after the rising edge that samples the strobe, because one state register sits between them. Slot n of the burst is therefore due n cycles later, and busy falls 140 cycles after the starting edge. The bench model consumes one queued slot at each rising edge and compares data, busy and bit clock in the middle of the low phase. It checks the bit clock again in the middle of the high phase, so each value is checked in the cycle it is due and nowhere else. Word updates and strobes during a burst, including one in the final busy cycle, are given to the model unchanged. The model ignores them because of its own idle rule.

// File: rtl/tlm_pkg.sv
package tlm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FLAG = 2'd1,
        ST_DATA = 2'd2,
        ST_TAIL = 2'd3
    } tlm_state_e;

    localparam logic FLAG_LEVEL = 1'b1;

endpackage

// File: rtl/tlm_burst_ctrl.sv
module tlm_burst_ctrl
    import tlm_pkg::*;
#(
    parameter int NUM_WORDS  = 4,
    parameter int WORD_W     = 32,
    parameter int BURST_CLKS = 140
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync_i,
    output tlm_state_e state_o,
    output logic       load_o,
    output logic       shift_o,
    output logic       busy_o,
    output logic       bit_en_o
);

    localparam int SLOT_CLKS = NUM_WORDS * (WORD_W + 1);
    localparam int TAIL_CLKS = BURST_CLKS - SLOT_CLKS;
    localparam int BIT_CW    = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam int WRD_CW    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
    localparam int TAIL_CW   = (TAIL_CLKS > 1) ? $clog2(TAIL_CLKS) : 1;
    localparam int CHK_CW    = $clog2(BURST_CLKS + 1);

    localparam logic [BIT_CW-1:0]  LAST_BIT  = BIT_CW'(WORD_W - 1);
    localparam logic [WRD_CW-1:0]  LAST_WORD = WRD_CW'(NUM_WORDS - 1);
    localparam logic [TAIL_CW-1:0] LAST_TAIL = TAIL_CW'(TAIL_CLKS - 1);

    tlm_state_e         state_q, state_d;
    logic [BIT_CW-1:0]  bit_cnt_q, bit_cnt_d;
    logic [WRD_CW-1:0]  word_cnt_q, word_cnt_d;
    logic [TAIL_CW-1:0] tail_cnt_q, tail_cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            bit_cnt_q  <= '0;
            word_cnt_q <= '0;
            tail_cnt_q <= '0;
        end else begin
            state_q    <= state_d;
            bit_cnt_q  <= bit_cnt_d;
            word_cnt_q <= word_cnt_d;
            tail_cnt_q <= tail_cnt_d;
        end
    end

    // transitions
    always_comb begin
        state_d    = state_q;
        bit_cnt_d  = bit_cnt_q;
        word_cnt_d = word_cnt_q;
        tail_cnt_d = tail_cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sync_i) begin
                    state_d    = ST_FLAG;
                    word_cnt_d = '0;
                end
            end
            ST_FLAG: begin
                state_d   = ST_DATA;
                bit_cnt_d = '0;
            end
            ST_DATA: begin
                if (bit_cnt_q == LAST_BIT) begin
                    bit_cnt_d = '0;
                    if (word_cnt_q == LAST_WORD) begin
                        state_d    = (TAIL_CLKS > 0) ? ST_TAIL : ST_IDLE;
                        tail_cnt_d = '0;
                    end else begin
                        state_d    = ST_FLAG;
                        word_cnt_d = word_cnt_q + 1'b1;
                    end
                end else begin
                    bit_cnt_d = bit_cnt_q + 1'b1;
                end
            end
            ST_TAIL: begin
                if (tail_cnt_q == LAST_TAIL) begin
                    state_d = ST_IDLE;
                end else begin
                    tail_cnt_d = tail_cnt_q + 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load_o   = 1'b0;
        shift_o  = 1'b0;
        busy_o   = 1'b1;
        bit_en_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy_o = 1'b0;
                load_o = sync_i;
            end
            ST_FLAG: bit_en_o = 1'b1;
            ST_DATA: begin
                bit_en_o = 1'b1;
                shift_o  = 1'b1;
            end
            ST_TAIL: ;
            default: busy_o = 1'b0;
        endcase
    end

    assign state_o = state_q;

    // checker counter for the burst window
    logic [CHK_CW-1:0] chk_busy_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      chk_busy_q <= '0;
        else if (busy_o) chk_busy_q <= chk_busy_q + 1'b1;
        else             chk_busy_q <= '0;
    end

    p_burst_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (chk_busy_q == CHK_CW'(BURST_CLKS)));

    p_start_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && sync_i) |=> (state_q == ST_FLAG && word_cnt_q == '0));

    p_flag_then_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLAG) |=> (state_q == ST_DATA && bit_cnt_q == '0));

    p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && sync_i && state_q != ST_DATA) |=> (state_q != ST_FLAG));

    p_tail_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TAIL) |-> (!bit_en_o && !shift_o));

endmodule

// File: rtl/tlm_shift_buf.sv
module tlm_shift_buf #(
    parameter int NUM_WORDS = 4,
    parameter int WORD_W    = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load_i,
    input  logic                        shift_i,
    input  logic [NUM_WORDS*WORD_W-1:0] words_i,
    output logic                        head_o
);

    localparam int TOTAL_W = NUM_WORDS * WORD_W;

    logic [TOTAL_W-1:0] buf_flat;

    // one lane per word; each lane takes its fill from the next lane's LSB
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_lane
        logic [WORD_W-1:0] lane_q;
        logic              fill_bit;

        if (w == NUM_WORDS - 1) begin : g_last
            assign fill_bit = 1'b0;
        end else begin : g_mid
            assign fill_bit = buf_flat[(w+1)*WORD_W];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       lane_q <= '0;
            else if (load_i)  lane_q <= words_i[w*WORD_W +: WORD_W];
            else if (shift_i) lane_q <= {fill_bit, lane_q[WORD_W-1:1]};
        end

        assign buf_flat[w*WORD_W +: WORD_W] = lane_q;
    end

    assign head_o = buf_flat[0];

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !shift_i) |=> $stable(buf_flat));

    p_lsb_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !load_i) |=> (buf_flat[TOTAL_W-2:0] == $past(buf_flat[TOTAL_W-1:1])));

endmodule

// File: rtl/tlm_serializer.sv
module tlm_serializer
    import tlm_pkg::*;
#(
    parameter int NUM_WORDS  = 4,
    parameter int WORD_W     = 32,
    parameter int BURST_CLKS = 140
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        settle_sync,
    input  logic [NUM_WORDS*WORD_W-1:0] word_bus,
    output logic                        ser_data,
    output logic                        bit_clk,
    output logic                        busy
);

    tlm_state_e state;
    logic       load, shift, bit_en, head;

    tlm_burst_ctrl #(
        .NUM_WORDS (NUM_WORDS),
        .WORD_W    (WORD_W),
        .BURST_CLKS(BURST_CLKS)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_i  (settle_sync),
        .state_o (state),
        .load_o  (load),
        .shift_o (shift),
        .busy_o  (busy),
        .bit_en_o(bit_en)
    );

    tlm_shift_buf #(
        .NUM_WORDS(NUM_WORDS),
        .WORD_W   (WORD_W)
    ) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .shift_i(shift),
        .words_i(word_bus),
        .head_o (head)
    );

    always_comb begin
        unique case (state)
            ST_FLAG: ser_data = FLAG_LEVEL;
            ST_DATA: ser_data = head;
            default: ser_data = 1'b0;
        endcase
    end

    // falls with the rising fast-clock edge that moves the data
    assign bit_clk = bit_en & ~clk;

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!ser_data && !bit_en));

    p_data_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_en) |-> !ser_data);

endmodule

// File: tb/tlm_serializer_bench.sv
module tlm_serializer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NW = 4;
    localparam int WW = 32;
    localparam int BURST = 140;
    localparam int SLOTS = NW * (WW + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          settle_sync = 1'b0;
    logic [NW*WW-1:0] word_bus = '0;
    logic          ser_data, bit_clk, busy;

    int checks = 0;
    int errors = 0;
    int cycle = 0;
    string phase = "R1";

    // expected slot stream: {valid_bit_slot, data}
    logic [1:0] exp_q[$];
    int         slot_pos[$];

    tlm_serializer u_tlm_serializer (
        .clk(clk), .rst_n(rst_n), .settle_sync(settle_sync),
        .word_bus(word_bus), .ser_data(ser_data), .bit_clk(bit_clk), .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s (%s) cycle %0d actual %b expected %b", req, phase, cycle, act, exp);
        end
    endtask

    // reference model: consume one slot per edge, start only when idle
    always @(posedge clk) begin
        cycle++;
        if (rst_n) begin
            automatic bit was_idle = (exp_q.size() == 0);
            if (!was_idle) begin
                void'(exp_q.pop_front());
                void'(slot_pos.pop_front());
            end
            if (was_idle && settle_sync) begin
                for (int w = 0; w < NW; w++) begin
                    exp_q.push_back(2'b11);
                    slot_pos.push_back(w * (WW + 1));
                    for (int b = 0; b < WW; b++) begin
                        exp_q.push_back({1'b1, word_bus[w*WW + b]});
                        slot_pos.push_back(w * (WW + 1) + 1 + b);
                    end
                end
                for (int t = 0; t < BURST - SLOTS; t++) begin
                    exp_q.push_back(2'b00);
                    slot_pos.push_back(SLOTS + t);
                end
            end
        end
    end

    // compare mid low phase (bit clock high in slots) and mid high phase
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            if (exp_q.size() == 0) begin
                check("R5 R9 idle busy", busy, 1'b0);
                check("R1 idle data", ser_data, 1'b0);
                check("R7 idle bitclk", bit_clk, 1'b0);
            end else begin
                automatic int p = slot_pos[0];
                check("R5 busy", busy, 1'b1);
                if (p >= SLOTS) begin
                    check("R6 tail data", ser_data, 1'b0);
                    check("R6 tail bitclk", bit_clk, 1'b0);
                end else begin
                    if (p % (WW + 1) == 0) check("R3 flag slot", ser_data, exp_q[0][0]);
                    else                   check("R4 data bit", ser_data, exp_q[0][0]);
                    check("R7 bitclk high", bit_clk, 1'b1);
                end
            end
        end
    end

    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (rst_n) check("R7 bitclk low in high phase", bit_clk, 1'b0);
    end

    task automatic pulse_sync();
        @(posedge clk); #2 settle_sync = 1'b1;
        @(posedge clk); #2 settle_sync = 1'b0;
    endtask

    task automatic wait_idle();
        while (exp_q.size() != 0 || busy) @(posedge clk);
        repeat (3) @(posedge clk);
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset busy", busy, 1'b0);
        check("R1 reset data", ser_data, 1'b0);
        check("R1 reset bitclk", bit_clk, 1'b0);
        @(negedge clk); #2 rst_n = 1'b1;
        repeat (4) @(posedge clk);

        // R2 R3 R4 R5: sign and LSB markers
        phase = "R2 R4 markers";
        #2 word_bus = {32'h8000_0001, 32'h0000_0000, 32'hFFFF_FFFF, 32'hA5C3_0F71};
        pulse_sync();
        wait_idle();

        // R8: words change every cycle during the burst
        phase = "R8 latch";
        #2 word_bus = {32'h1234_5678, 32'h8765_4321, 32'hDEAD_BEEF, 32'h0BAD_F00D};
        pulse_sync();
        for (int i = 0; i < 60; i++) begin
            @(posedge clk); #2 word_bus = {$urandom, $urandom, $urandom, $urandom};
        end
        wait_idle();

        // R9: strobes mid-burst and in the last busy cycle
        phase = "R9 ignore";
        #2 word_bus = {$urandom, $urandom, $urandom, $urandom};
        pulse_sync();
        repeat (20) @(posedge clk);
        pulse_sync();
        repeat (100) @(posedge clk);
        pulse_sync();
        while (busy) @(posedge clk);
        repeat (3) @(posedge clk);

        // R10: strobe held high -> back-to-back bursts
        phase = "R10 continuous";
        #2 settle_sync = 1'b1;
        for (int i = 0; i < 3 * (BURST + 1); i++) begin
            @(posedge clk); #2 word_bus = {$urandom, $urandom, $urandom, $urandom};
        end
        settle_sync = 1'b0;
        wait_idle();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule